// File: doc/BRIEF.md
# Twin-Channel Down-Counting Interval Timer

This block holds two independent down-counting timer channels that software reaches through a single-cycle register bus. Each channel owns a 16-byte register window holding a control/status word, the live count and two reload words. A channel starts counting when software writes its control word with the count-enable bit and the self-clearing start bit both at 1. That write copies the first reload word into the counter. From then on the counter steps down once per prescaled tick.

When a tick arrives while the count is already zero, the channel records an underflow in a sticky flag. In periodic mode it then reloads from the first reload word and keeps going. In one-shot mode it parks at zero. A per-channel interrupt line stays high while the flag and the interrupt-enable bit are both set. Software acknowledges by writing the control word with the flag bit at 0. A typical use dedicates one channel to periodic or one-shot event interrupts and leaves the other free-running in periodic mode as a monotonic time base.

Top module: `twin_down_timer`

## Requirements
- R1: Channel c occupies byte addresses 0x10*c to 0x10*c+0xF. Inside the window, offset 0x0 is the control word, 0x4 the count, 0x8 reload word A and 0xC reload word B. Reads return data combinationally in the same cycle. An address that is not a multiple of 4, or that selects no channel, writes nothing and reads 0.
- R2: Control word bits: 0 start (write only), 1 count enable, 2 underflow flag, 3 interrupt enable, 4 auto-reload, 5 output level, [11:10] clock select. The output level bit drives that channel's `lvl_out` pin. All other bits read 0.
- R3: A control write with bits 0 and 1 both at 1 loads reload word A into the count on that edge and restarts the prescaler. A write with bit 0 at 1 and bit 1 at 0 does not load the count and does not start the channel.
- R4: The start bit always reads back as 0.
- R5: With clock select s, a running channel decrements once every 2^(s+1) clock cycles. The first decrement comes one full prescale period after the start edge, so reload value N underflows (N+1)*2^(s+1) cycles after the start edge.
- R6: A tick at count 0 sets the underflow flag. With auto-reload at 1, the count reloads from word A and the channel keeps running, so a reload value of 0 underflows on every tick.
- R7: With auto-reload at 0, the channel stops at count 0 after its underflow and raises no further underflows until it is started again.
- R8: A control write with bit 2 at 0 clears the flag. A write with bit 2 at 1 leaves the flag unchanged. An underflow on the same edge as a clearing write leaves the flag set.
- R9: `irq[c]` is high exactly while channel c's flag and interrupt-enable bit are both 1.
- R10: A control write with bit 1 at 0 halts the channel. The count then holds its value, and only a new start resumes counting.
- R11: Writing the count word loads the count directly. Reload word B is plain read/write storage with no effect on counting.
- R12: A synchronous active-low reset clears all control bits, the prescalers, all counts and all reload words.
- R13: The channels are independent: writing one channel changes no register of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq | output | NCH | Per-channel interrupt level |
| lvl_out | output | NCH | Per-channel output level bit |

## Verification
The bench builds the block with its defaults: two 32-bit channels and a 5-bit address. Because a start always loads the counter from reload word A, small reload values (0 to 3) bring every underflow, reload and one-shot stop within a few dozen cycles, even though the counter is 32 bits wide. Across the tests, clock select takes the values 0, 1 and 3. That covers divisors of 2, 4 and 16, including the widest prescale period. The bench also lines up a flag-clearing write with an underflow edge on purpose, to exercise that collision.

// File: rtl/twin_timer_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the twin down-counting timer.
// Assumes a 32-bit register bus and a 2-bit clock-select field.
package twin_timer_pkg;
    localparam int DATA_W   = 32;
    localparam int CSEL_W   = 2;

    // Control word bit positions; software depends on these.
    localparam int BIT_START = 0;
    localparam int BIT_EN    = 1;
    localparam int BIT_UF    = 2;
    localparam int BIT_IE    = 3;
    localparam int BIT_AUTO  = 4;
    localparam int BIT_LVL   = 5;
    localparam int CSEL_LSB  = 10;

    // Word selector inside a channel window (address bits [3:2]).
    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_COUNT = 2'd1,
        REG_RLD_A = 2'd2,
        REG_RLD_B = 2'd3
    } reg_sel_e;

    // Stored control state of one channel (start bit is not stored).
    typedef struct packed {
        logic [CSEL_W-1:0] csel;
        logic              lvl;
        logic              autold;
        logic              ie;
        logic              uf;
        logic              en;
    } ctrl_t;

    // Build the software-visible control word; start bit reads as 0.
    function automatic logic [DATA_W-1:0] ctrl_word(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[BIT_EN]   = c.en;
        w[BIT_UF]   = c.uf;
        w[BIT_IE]   = c.ie;
        w[BIT_AUTO] = c.autold;
        w[BIT_LVL]  = c.lvl;
        w[CSEL_LSB +: CSEL_W] = c.csel;
        return w;
    endfunction
endpackage

// File: rtl/tmr_prescale.sv
`timescale 1ns/1ps
// Tick generator for one channel: emits a one-cycle tick every
// 2^(csel+1) cycles while run is high. Assumes restart is pulsed on
// the start edge so the first tick comes one full period later.
module tmr_prescale #(
    parameter int CSEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              restart,
    input  logic [CSEL_W-1:0] csel,
    output logic              tick
);
    localparam int PS_W = 1 << CSEL_W;

    logic [PS_W-1:0] pcnt;
    logic [PS_W-1:0] term;

    // Terminal value of the divider for the selected period.
    always_comb term = PS_W'((2 << csel) - 1);

    // Tick on the terminal count of a running divider.
    always_comb tick = run && (pcnt == term);

    // Divider state: cleared on reset, restart or while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)               pcnt <= '0;
        else if (restart || !run) pcnt <= '0;
        else if (tick)            pcnt <= '0;
        else                      pcnt <= pcnt + 1'b1;
    end
endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
// One timer channel: control word, down counter, two reload words
// and an interrupt level. Assumes at most one of the write strobes
// is high in a cycle (one bus access per cycle).
module tmr_channel
    import twin_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic              count_we,
    input  logic              rld_a_we,
    input  logic              rld_b_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [CNT_W-1:0]  count_q,
    output logic [CNT_W-1:0]  rld_a_q,
    output logic [CNT_W-1:0]  rld_b_q,
    output logic              irq,
    output logic              lvl,
    output logic              tick,
    output logic              start,
    output logic              armed
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] rld_a;
    logic [CNT_W-1:0] rld_b;
    logic             armed_q;
    logic             run;
    logic             uflow;

    // A start needs both the start bit and count enable in one write.
    always_comb start = ctrl_we && wdata[BIT_START] && wdata[BIT_EN];
    always_comb run   = armed_q && ctrl.en;
    always_comb uflow = tick && (count == '0);

    tmr_prescale #(.CSEL_W(CSEL_W)) u_ps (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (start),
        .csel    (ctrl.csel),
        .tick    (tick)
    );

    // Control word: software fields, and a sticky flag that hardware sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (ctrl_we) begin
            ctrl.en     <= wdata[BIT_EN];
            ctrl.ie     <= wdata[BIT_IE];
            ctrl.autold <= wdata[BIT_AUTO];
            ctrl.lvl    <= wdata[BIT_LVL];
            ctrl.csel   <= wdata[CSEL_LSB +: CSEL_W];
            ctrl.uf     <= (wdata[BIT_UF] & ctrl.uf) | uflow;
        end else if (uflow) begin
            ctrl.uf     <= 1'b1;
        end
    end

    // Armed state: set by a start, dropped by disable or one-shot end.
    always_ff @(posedge clk) begin
        if (!rst_n)                                armed_q <= 1'b0;
        else if (start)                            armed_q <= 1'b1;
        else if (ctrl_we && !wdata[BIT_EN])        armed_q <= 1'b0;
        else if (uflow && !ctrl.autold)            armed_q <= 1'b0;
    end

    // Counter: start load, direct write, reload on underflow, else step down.
    always_ff @(posedge clk) begin
        if (!rst_n)        count <= '0;
        else if (start)    count <= rld_a;
        else if (count_we) count <= wdata[CNT_W-1:0];
        else if (tick) begin
            if (count == '0) count <= ctrl.autold ? rld_a : count;
            else             count <= count - 1'b1;
        end
    end

    // Reload words: plain storage written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rld_a <= '0;
            rld_b <= '0;
        end else begin
            if (rld_a_we) rld_a <= wdata[CNT_W-1:0];
            if (rld_b_we) rld_b <= wdata[CNT_W-1:0];
        end
    end

    // Outputs toward the bus port and the pins.
    always_comb begin
        ctrl_q  = ctrl_word(ctrl);
        count_q = count;
        rld_a_q = rld_a;
        rld_b_q = rld_b;
        irq     = ctrl.uf & ctrl.ie;
        lvl     = ctrl.lvl;
        armed   = armed_q;
    end
endmodule

// File: rtl/tmr_bus_port.sv
`timescale 1ns/1ps
// Register bus port: decodes the address into per-channel write
// strobes and returns read data combinationally. Assumes word-aligned
// accesses; a misaligned or out-of-range address is ignored.
module tmr_bus_port
    import twin_timer_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int ADDR_W = 5
) (
    input  logic                       bus_sel,
    input  logic                       bus_wr,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [NCH-1:0][DATA_W-1:0] ctrl_rd,
    input  logic [NCH-1:0][DATA_W-1:0] count_rd,
    input  logic [NCH-1:0][DATA_W-1:0] rld_a_rd,
    input  logic [NCH-1:0][DATA_W-1:0] rld_b_rd,
    output logic [NCH-1:0]             we_ctrl,
    output logic [NCH-1:0]             we_count,
    output logic [NCH-1:0]             we_rla,
    output logic [NCH-1:0]             we_rlb,
    output logic [DATA_W-1:0]          bus_rdata
);
    localparam int CHS_W = ADDR_W - 4;

    logic [CHS_W-1:0] chan;
    reg_sel_e         rsel;
    logic             hit;

    // Address split and validity of the access.
    always_comb begin
        chan = bus_addr[ADDR_W-1:4];
        rsel = reg_sel_e'(bus_addr[3:2]);
        hit  = bus_sel && (bus_addr[1:0] == 2'b00) && (int'(chan) < NCH);
    end

    // Per-channel write strobes.
    for (genvar g = 0; g < NCH; g++) begin : g_we
        logic wsel;
        always_comb begin
            wsel        = bus_wr && hit && (int'(chan) == g);
            we_ctrl[g]  = wsel && (rsel == REG_CTRL);
            we_count[g] = wsel && (rsel == REG_COUNT);
            we_rla[g]   = wsel && (rsel == REG_RLD_A);
            we_rlb[g]   = wsel && (rsel == REG_RLD_B);
        end
    end

    // Read multiplexer: selected word of the addressed channel.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (hit && (int'(chan) == i)) begin
                case (rsel)
                    REG_CTRL:  bus_rdata = ctrl_rd[i];
                    REG_COUNT: bus_rdata = count_rd[i];
                    REG_RLD_A: bus_rdata = rld_a_rd[i];
                    default:   bus_rdata = rld_b_rd[i];
                endcase
            end
        end
    end
endmodule

// File: rtl/twin_down_timer.sv
`timescale 1ns/1ps
// Top of the twin down-counting timer: NCH channels behind a
// single-cycle register bus. Assumes ADDR_W >= 5 and CNT_W <= 32.
module twin_down_timer
    import twin_timer_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NCH-1:0]    irq,
    output logic [NCH-1:0]    lvl_out
);
    logic [NCH-1:0][DATA_W-1:0] ctrl_rd;
    logic [NCH-1:0][DATA_W-1:0] count_rd;
    logic [NCH-1:0][DATA_W-1:0] rld_a_rd;
    logic [NCH-1:0][DATA_W-1:0] rld_b_rd;
    logic [NCH-1:0]             we_ctrl;
    logic [NCH-1:0]             we_count;
    logic [NCH-1:0]             we_rla;
    logic [NCH-1:0]             we_rlb;
    logic [NCH-1:0]             tick_v;
    logic [NCH-1:0]             start_v;
    logic [NCH-1:0]             armed_v;
    logic [NCH-1:0]             uf_v;
    logic [NCH-1:0]             auto_v;
    logic [NCH-1:0][CNT_W-1:0]  cnt_v;
    logic [NCH-1:0][CNT_W-1:0]  rla_v;

    tmr_bus_port #(.NCH(NCH), .ADDR_W(ADDR_W)) u_port (
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .ctrl_rd   (ctrl_rd),
        .count_rd  (count_rd),
        .rld_a_rd  (rld_a_rd),
        .rld_b_rd  (rld_b_rd),
        .we_ctrl   (we_ctrl),
        .we_count  (we_count),
        .we_rla    (we_rla),
        .we_rlb    (we_rlb),
        .bus_rdata (bus_rdata)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [CNT_W-1:0] rlb;
        tmr_channel #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .ctrl_we  (we_ctrl[g]),
            .count_we (we_count[g]),
            .rld_a_we (we_rla[g]),
            .rld_b_we (we_rlb[g]),
            .wdata    (bus_wdata),
            .ctrl_q   (ctrl_rd[g]),
            .count_q  (cnt_v[g]),
            .rld_a_q  (rla_v[g]),
            .rld_b_q  (rlb),
            .irq      (irq[g]),
            .lvl      (lvl_out[g]),
            .tick     (tick_v[g]),
            .start    (start_v[g]),
            .armed    (armed_v[g])
        );

        // Widen channel words to the bus width and expose flag state.
        always_comb begin
            count_rd[g] = DATA_W'(cnt_v[g]);
            rld_a_rd[g] = DATA_W'(rla_v[g]);
            rld_b_rd[g] = DATA_W'(rlb);
            uf_v[g]     = ctrl_rd[g][BIT_UF];
            auto_v[g]   = ctrl_rd[g][BIT_AUTO];
        end
    end
endmodule

// File: rtl/twin_down_timer_chk.sv
`timescale 1ns/1ps
// Property checker for the twin down-counting timer, bound to the top.
// Assumes the top exposes per-channel tick, start, armed and flags.
module twin_down_timer_chk #(
    parameter int NCH   = 2,
    parameter int CNT_W = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NCH-1:0]            start_v,
    input logic [NCH-1:0]            we_count,
    input logic [NCH-1:0]            we_ctrl,
    input logic [NCH-1:0]            tick_v,
    input logic [NCH-1:0]            armed_v,
    input logic [NCH-1:0]            uf_v,
    input logic [NCH-1:0]            auto_v,
    input logic [NCH-1:0][CNT_W-1:0] cnt_v,
    input logic [NCH-1:0][CNT_W-1:0] rla_v
);
    for (genvar g = 0; g < NCH; g++) begin : g_prop
        assert_start_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
            start_v[g] |=> (cnt_v[g] == $past(rla_v[g])) && armed_v[g]);

        assert_step_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (tick_v[g] && (cnt_v[g] != '0) && !start_v[g] && !we_count[g])
            |=> cnt_v[g] == CNT_W'($past(cnt_v[g]) - 1'b1));

        assert_tick_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
            tick_v[g] |=> !tick_v[g]);

        assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (tick_v[g] && (cnt_v[g] == '0)) |=> uf_v[g]);

        assert_oneshot_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (tick_v[g] && (cnt_v[g] == '0) && !auto_v[g] && !we_ctrl[g]) |=> !armed_v[g]);

        assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (!armed_v[g] && !start_v[g] && !we_count[g]) |=> $stable(cnt_v[g]));
    end
endmodule

bind twin_down_timer twin_down_timer_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/twin_down_timer_test.sv
`timescale 1ns/1ps
// Bench for the twin down-counting timer: a behavioural model stepped
// every clock, compared on every cycle, plus directed checks.
module twin_down_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;
    logic [1:0]  lvl_out;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    twin_down_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .lvl_out(lvl_out)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // ---- behavioural model ----
    bit          m_en[2], m_uf[2], m_ie[2], m_au[2], m_lv[2], m_arm[2];
    int          m_cs[2], m_pc[2];
    logic [31:0] m_cnt[2], m_ra[2], m_rb[2];

    always @(posedge clk) begin
        for (int c = 0; c < 2; c++) begin
            bit hw;
            bit hitc;
            hw = 0;
            if (!rst_n) begin
                m_en[c] = 0; m_uf[c] = 0; m_ie[c] = 0; m_au[c] = 0; m_lv[c] = 0;
                m_arm[c] = 0; m_cs[c] = 0; m_pc[c] = 0;
                m_cnt[c] = 0; m_ra[c] = 0; m_rb[c] = 0;
            end else begin
                if (m_arm[c] && m_en[c]) begin
                    if (m_pc[c] == (2 << m_cs[c]) - 1) begin
                        m_pc[c] = 0;
                        if (m_cnt[c] == 0) begin
                            hw = 1;
                            if (m_au[c]) m_cnt[c] = m_ra[c];
                            else m_arm[c] = 0;
                        end else m_cnt[c] = m_cnt[c] - 1;
                    end else m_pc[c] = m_pc[c] + 1;
                end
                hitc = bus_sel && bus_wr && bus_addr[1:0] == 0 && bus_addr[4] == c[0];
                if (hitc && bus_addr[3:2] == 0) begin
                    m_uf[c] = (bus_wdata[2] & m_uf[c]) | hw;
                    m_en[c] = bus_wdata[1]; m_ie[c] = bus_wdata[3];
                    m_au[c] = bus_wdata[4]; m_lv[c] = bus_wdata[5];
                    m_cs[c] = int'(bus_wdata[11:10]);
                    if (bus_wdata[0] && bus_wdata[1]) begin
                        m_cnt[c] = m_ra[c]; m_arm[c] = 1; m_pc[c] = 0;
                    end else if (!bus_wdata[1]) m_arm[c] = 0;
                end else begin
                    if (hw) m_uf[c] = 1;
                    if (hitc && bus_addr[3:2] == 1) m_cnt[c] = bus_wdata;
                    if (hitc && bus_addr[3:2] == 2) m_ra[c] = bus_wdata;
                    if (hitc && bus_addr[3:2] == 3) m_rb[c] = bus_wdata;
                end
            end
        end
    end

    function automatic logic [31:0] mread(input logic [4:0] a);
        int c;
        c = int'(a[4]);
        if (a[1:0] != 0) return 32'h0;
        case (a[3:2])
            2'd0: return {20'h0, 2'(m_cs[c]), 4'h0, m_lv[c], m_au[c], m_ie[c], m_uf[c], m_en[c], 1'b0};
            2'd1: return m_cnt[c];
            2'd2: return m_ra[c];
            default: return m_rb[c];
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Every-cycle comparison against the model, away from the edge.
    always @(negedge clk) begin
        #1;
        if (cmp_on) begin
            for (int c = 0; c < 2; c++) begin
                check("R9 irq level vs model", 32'(irq[c]), 32'(m_uf[c] & m_ie[c]));
                check("R2 lvl_out vs model", 32'(lvl_out[c]), 32'(m_lv[c]));
            end
            if (bus_sel && !bus_wr) check("R1 read data vs model", bus_rdata, mread(bus_addr));
        end
    end

    // Tasks start at a falling edge and return at the next one.
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1.5 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic wait_to(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            compared++; mismatched++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v, hold;
        int t;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        cmp_on = 1;

        // R12: reset values
        for (int a = 0; a < 32; a += 4) begin
            rd(5'(a), v); check("R12 reset register", v, 0);
        end
        check("R12 reset irq", 32'(irq), 0);

        // R1: misaligned write ignored
        wr(5'h09, 32'h5);
        rd(5'h08, v); check("R1 misaligned write ignored", v, 0);
        rd(5'h09, v); check("R1 misaligned read is zero", v, 0);

        // Channel 0 periodic, reload 3, divide by 2
        wr(5'h08, 3);
        wr(5'h00, 32'h1B);
        t = cyc;
        rd(5'h04, v); check("R3 start loads reload A", v, 3);
        rd(5'h00, v); check("R4 start bit reads 0", v, 32'h1A);
        rd(5'h04, v); check("R5 first step after one period", v, 2);
        wait_to(t + 7);
        check("R6 no irq before underflow", 32'(irq[0]), 0);
        rd(5'h04, v); check("R6 count at zero", v, 0);
        check("R6 irq at underflow edge", 32'(irq[0]), 1);
        rd(5'h04, v); check("R6 periodic reload", v, 3);
        wr(5'h00, 32'h1E);
        check("R8 writing flag 1 keeps it", 32'(irq[0]), 1);
        wr(5'h00, 32'h1A);
        check("R8 writing flag 0 clears it", 32'(irq[0]), 0);
        wait_to(t + 15);
        wr(5'h00, 32'h1A);
        check("R8 underflow wins over clear", 32'(irq[0]), 1);

        // R10: disable halts and holds
        wr(5'h00, 32'h18);
        rd(5'h04, hold);
        repeat (10) @(negedge clk);
        rd(5'h04, v); check("R10 count holds when disabled", v, hold);
        check("R10 flag cleared by write", 32'(irq[0]), 0);

        // Channel 1 reload 0, interrupt disabled
        wr(5'h18, 0);
        wr(5'h10, 32'h13);
        t = cyc;
        wait_to(t + 2);
        rd(5'h10, v); check("R6 reload 0 underflows each tick", v, 32'h16);
        check("R9 no irq without enable", 32'(irq[1]), 0);
        wr(5'h10, 32'h1A);
        repeat (3) @(negedge clk);
        check("R9 irq with enable and flag", 32'(irq[1]), 1);
        wr(5'h10, 0);

        // Channel 1 one-shot, reload 2, divide by 4
        wr(5'h18, 2);
        wr(5'h10, 32'h40B);
        t = cyc;
        wait_to(t + 11);
        check("R5 divide by 4 not yet", 32'(irq[1]), 0);
        wait_to(t + 12);
        check("R5 divide by 4 underflow", 32'(irq[1]), 1);
        rd(5'h14, v); check("R7 one-shot parks at 0", v, 0);
        repeat (20) @(negedge clk);
        rd(5'h14, v); check("R7 stays at 0", v, 0);
        wr(5'h10, 32'h40A);
        repeat (20) @(negedge clk);
        check("R7 no further underflow", 32'(irq[1]), 0);
        rd(5'h08, v); check("R13 ch0 reload untouched", v, 3);

        // Channel 0 periodic, reload 1, divide by 16
        wr(5'h08, 1);
        wr(5'h00, 32'hC1B);
        t = cyc;
        wait_to(t + 31);
        check("R5 divide by 16 not yet", 32'(irq[0]), 0);
        wait_to(t + 32);
        check("R5 divide by 16 underflow", 32'(irq[0]), 1);
        rd(5'h00, v); check("R2 control field layout", v, 32'hC1E);
        wr(5'h00, 0);

        // R3 start without enable, R11 direct count and reload B
        wr(5'h08, 7);
        wr(5'h04, 100);
        rd(5'h04, v); check("R11 direct count write", v, 100);
        wr(5'h00, 32'h01);
        rd(5'h04, v); check("R3 start without enable ignored", v, 100);
        wr(5'h0C, 32'hDEADBEEF);
        rd(5'h0C, v); check("R11 reload B storage", v, 32'hDEADBEEF);
        rd(5'h04, v); check("R11 reload B no effect", v, 100);

        // R2 level pin and undefined bits
        wr(5'h10, 32'hFFFFF3E0);
        rd(5'h10, v); check("R2 undefined bits read 0", v, 32'h20);
        check("R2 level pin", 32'(lvl_out), 2);
        rd(5'h04, v); check("R13 ch0 count untouched", v, 100);

        done = 1;
        finish_run();
    end
endmodule